// File: doc/BRIEF.md
# DRAM Clock Frequency Change Sequencer

This block sits on the controller side of a DDR2-class SDRAM interface. It steps the device through a change of its input clock frequency. A change request is accepted only while the sequencer is ready. The block then captures the timing configuration and turns the termination enable off. It closes any open bank with a precharge-all command and waits out the precharge and termination-off times. After that it drops the clock enable into precharge power-down and, after a fixed margin, signals the clock generator that the frequency may be switched.

When the clock generator reports the new clock as stable, the sequencer raises the clock enable. It waits out the power-down exit time, then issues a mode register write that resets the DLL. Termination is held off for the whole relock window. The ready flag returns only when that window has closed. Every cycle of the sequence that carries no named command drives NOP.

Top module: `freq_chg_seq`

## Requirements
- R1: Out of reset, and whenever the sequencer is idle, `ready`=1, `cke`=1, `cmd`=NOP (2'b00), `clk_sw_ok`=0 and `odt_en` equals `odt_req`.
- R2: A `chg_req` seen high at a clock edge while idle starts a sequence. In the next cycle `ready`=0 and `odt_en`=0, and `cmd` is precharge-all (2'b01) if `bank_open` was high at acceptance, otherwise NOP.
- R3: `odt_en` stays 0 in every cycle in which `ready` is 0, including the whole relock window.
- R4: `cke` falls exactly M+2 cycles after the cycle in which `odt_en` fell. M is the larger of the captured tAOFD and the captured tRP, and the captured tRP counts as 0 when no bank was open.
- R5: `clk_sw_ok` rises MARGIN (2) cycles after `cke` falls. It stays high, with `cke` low and `cmd` NOP, until `clk_stable` is sampled high.
- R6: The cycle after `clk_stable` is sampled high while `clk_sw_ok` is high, `cke` is 1 and `clk_sw_ok` is 0.
- R7: The DLL-reset mode register write (2'b10) is driven for exactly one cycle, tXP+1 cycles after the cycle in which `cke` rose.
- R8: `ready` returns exactly RELOCK_CYC+1 cycles after the DLL-reset cycle.
- R9: A sequence drives exactly one DLL-reset command and at most one precharge-all, which appears only when a bank was open. All other cycles carry NOP, and NOP is driven whenever `cke` is low.
- R10: `cfg_trp`, `cfg_taofd`, `cfg_txp` and `bank_open` are captured at acceptance. Later changes do not alter any interval of the running sequence.
- R11: `chg_req` is ignored while a sequence runs. A request that was held during the sequence and dropped once `ready` returns does not start a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_req | input | 1 | Request a frequency change |
| bank_open | input | 1 | At least one bank is open |
| clk_stable | input | 1 | Clock generator reports the new clock stable |
| odt_req | input | 1 | Termination wanted by normal traffic |
| cfg_trp | input | CFG_W | Precharge time in cycles |
| cfg_taofd | input | CFG_W | Termination-off time in cycles |
| cfg_txp | input | CFG_W | Power-down exit time in cycles |
| cmd | output | 2 | Command: 00 NOP, 01 precharge-all, 10 DLL-reset mode write |
| cke | output | 1 | Clock enable to the device |
| odt_en | output | 1 | Termination enable to the device |
| clk_sw_ok | output | 1 | Frequency may be switched now |
| ready | output | 1 | Device usable at the current clock |

## Verification
The bench builds the block with CFG_W=4 and RELOCK_CYC=24. The narrow configuration lets random draws regularly hit zero and the all-ones value 15, where tRP or tAOFD wins the maximum in turn. The short relock window lets dozens of complete sequences run within the cycle budget, each with random clock-stable delays, request noise and configuration noise. Every interval is timed from the ports against values computed from the captured configuration.

// File: rtl/freq_chg_pkg.sv
// Shared types for the frequency change sequencer.
// Assumes a two-bit command bus decoded by the command path downstream.
package freq_chg_pkg;

    typedef enum logic [1:0] {
        DCMD_NOP     = 2'b00,
        DCMD_PRE_ALL = 2'b01,
        DCMD_DLL_RST = 2'b10
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DRAIN,
        ST_MARGIN,
        ST_SWITCH,
        ST_XP,
        ST_DLL,
        ST_RELOCK
    } seq_st_e;

endpackage

// File: rtl/fcs_timer.sv
// Down-counting interval timer.
// Loads load_val on load, then counts down one per cycle and holds at zero.
// expired is high while the count is zero. Assumes load is a single-cycle pulse.
module fcs_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R4: an expired timer does not wrap when no load comes in.
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

    // R4: a load of a nonzero value makes the timer pending next cycle.
    p_load_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/fcs_cfg_hold.sv
// Captures the timing configuration and open-bank status at sequence start.
// Assumes capture is a single-cycle pulse at request acceptance.
module fcs_cfg_hold #(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CFG_W-1:0] trp_in,
    input  logic [CFG_W-1:0] taofd_in,
    input  logic [CFG_W-1:0] txp_in,
    input  logic             bank_in,
    output logic [CFG_W-1:0] trp_q,
    output logic [CFG_W-1:0] taofd_q,
    output logic [CFG_W-1:0] txp_q,
    output logic             bank_q
);

    // Hold the configuration for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trp_q   <= '0;
            taofd_q <= '0;
            txp_q   <= '0;
            bank_q  <= 1'b0;
        end else if (capture) begin
            trp_q   <= trp_in;
            taofd_q <= taofd_in;
            txp_q   <= txp_in;
            bank_q  <= bank_in;
        end
    end

    // R10: held values change only on a capture.
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(trp_q) && $stable(taofd_q) && $stable(txp_q) && $stable(bank_q));

endmodule

// File: rtl/freq_chg_seq.sv
// Frequency change sequencer: walks the device through precharge, termination
// off, power-down, clock switch, power-down exit, DLL reset and relock.
// Assumes the device is otherwise idle once a request is accepted and that
// RELOCK_CYC and MARGIN are at least 1. All outputs decode from the state register.
module freq_chg_seq
    import freq_chg_pkg::*;
#(
    parameter int CFG_W      = 4,
    parameter int MARGIN     = 2,
    parameter int RELOCK_CYC = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chg_req,
    input  logic             bank_open,
    input  logic             clk_stable,
    input  logic             odt_req,
    input  logic [CFG_W-1:0] cfg_trp,
    input  logic [CFG_W-1:0] cfg_taofd,
    input  logic [CFG_W-1:0] cfg_txp,
    output logic [1:0]       cmd,
    output logic             cke,
    output logic             odt_en,
    output logic             clk_sw_ok,
    output logic             ready
);

    localparam int MG_W  = $clog2(MARGIN + 1);
    localparam int RLK_W = $clog2(RELOCK_CYC + 1);
    localparam logic [MG_W-1:0]  MG_LOAD  = MG_W'(MARGIN - 1);
    localparam logic [RLK_W-1:0] RLK_LOAD = RLK_W'(RELOCK_CYC - 1);

    seq_st_e          state_q, state_d;
    logic             accept;
    logic [CFG_W-1:0] h_trp, h_taofd, h_txp;
    logic             h_bank;
    logic             trp_exp, aofd_exp, mg_exp, xp_exp, rlk_exp;
    logic             drain_done, stable_seen;

    assign accept      = (state_q == ST_IDLE) && chg_req;
    assign drain_done  = (state_q == ST_DRAIN) && trp_exp && aofd_exp;
    assign stable_seen = (state_q == ST_SWITCH) && clk_stable;

    fcs_cfg_hold #(.CFG_W(CFG_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .capture(accept),
        .trp_in(cfg_trp), .taofd_in(cfg_taofd), .txp_in(cfg_txp), .bank_in(bank_open),
        .trp_q(h_trp), .taofd_q(h_taofd), .txp_q(h_txp), .bank_q(h_bank)
    );

    fcs_timer #(.W(CFG_W)) u_trp (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_PRE),
        .load_val(h_bank ? h_trp : '0), .expired(trp_exp)
    );

    fcs_timer #(.W(CFG_W)) u_aofd (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_PRE),
        .load_val(h_taofd), .expired(aofd_exp)
    );

    fcs_timer #(.W(MG_W)) u_margin (
        .clk(clk), .rst_n(rst_n), .load(drain_done),
        .load_val(MG_LOAD), .expired(mg_exp)
    );

    fcs_timer #(.W(CFG_W)) u_txp (
        .clk(clk), .rst_n(rst_n), .load(stable_seen),
        .load_val(h_txp), .expired(xp_exp)
    );

    fcs_timer #(.W(RLK_W)) u_relock (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_DLL),
        .load_val(RLK_LOAD), .expired(rlk_exp)
    );

    // Next-state selection for the sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (chg_req)     state_d = ST_PRE;
            ST_PRE:                     state_d = ST_DRAIN;
            ST_DRAIN:  if (drain_done)  state_d = ST_MARGIN;
            ST_MARGIN: if (mg_exp)      state_d = ST_SWITCH;
            ST_SWITCH: if (clk_stable)  state_d = ST_XP;
            ST_XP:     if (xp_exp)      state_d = ST_DLL;
            ST_DLL:                     state_d = ST_RELOCK;
            ST_RELOCK: if (rlk_exp)     state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the state register.
    always_comb begin
        cmd = DCMD_NOP;
        if (state_q == ST_PRE && h_bank) cmd = DCMD_PRE_ALL;
        if (state_q == ST_DLL)           cmd = DCMD_DLL_RST;
        cke       = !(state_q == ST_MARGIN || state_q == ST_SWITCH);
        odt_en    = (state_q == ST_IDLE) && odt_req;
        clk_sw_ok = (state_q == ST_SWITCH);
        ready     = (state_q == ST_IDLE);
    end

    // R1: the ready state drives a powered-up, quiet bus.
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cke && cmd == DCMD_NOP && !clk_sw_ok));

    // R3: termination stays off while not ready.
    p_odt_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !odt_en);

    // R5: the switch window only exists with CKE low.
    p_sw_cke_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sw_ok |-> !cke);

    // R6: a stable clock in the window raises CKE next cycle.
    p_cke_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sw_ok && clk_stable) |=> (cke && !clk_sw_ok));

    // R7: the DLL reset lasts a single cycle.
    p_dll_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == DCMD_DLL_RST) |=> (cmd == DCMD_NOP));

    // R9: no command while in power-down.
    p_nop_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd == DCMD_NOP));

    // R11: a request only leaves the ready state from ready.
    p_req_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(chg_req));

endmodule

// File: tb/freq_chg_seq_bench.sv
module freq_chg_seq_bench;

    localparam int CFG_W  = 4;
    localparam int RELOCK = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chg_req = 1'b0, bank_open = 1'b0, clk_stable = 1'b0, odt_req = 1'b0;
    logic [CFG_W-1:0] cfg_trp = '0, cfg_taofd = '0, cfg_txp = '0;
    logic [1:0]       cmd;
    logic             cke, odt_en, clk_sw_ok, ready;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #10 clk = ~clk;

    freq_chg_seq #(.CFG_W(CFG_W), .MARGIN(2), .RELOCK_CYC(RELOCK)) u_freq_chg_seq (
        .clk(clk), .rst_n(rst_n), .chg_req(chg_req), .bank_open(bank_open),
        .clk_stable(clk_stable), .odt_req(odt_req), .cfg_trp(cfg_trp),
        .cfg_taofd(cfg_taofd), .cfg_txp(cfg_txp), .cmd(cmd), .cke(cke),
        .odt_en(odt_en), .clk_sw_ok(clk_sw_ok), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_m(input int trp, input int taofd, input bit bank);
        int t;
        t = bank ? trp : 0;
        return (t > taofd) ? t : taofd;
    endfunction

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic idle_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chg_req = 1'b0;
            odt_req = 1'($urandom);
            #1;
            chk(ready && cke && cmd == 2'b00 && !clk_sw_ok, "R1 idle", {ready, cke, clk_sw_ok}, 3'b110);
            chk(odt_en == odt_req, "R1 odt follow", odt_en, odt_req);
            @(posedge clk);
            #1;
            chk(ready, "R11 no restart", ready, 1);
        end
    endtask

    task automatic run_seq(input int trp, input int taofd, input int txp, input bit bank, input int dly);
        int k = 0, t_ckef = -1, t_sw = -1, t_ckeu = -1, t_dll = -1, t_rdy = -1;
        int n_pre = 0, n_dll = 0, n_sw = 0, m;
        @(negedge clk);
        chg_req = 1'b1; bank_open = bank; clk_stable = 1'b0; odt_req = 1'b1;
        cfg_trp = CFG_W'(trp); cfg_taofd = CFG_W'(taofd); cfg_txp = CFG_W'(txp);
        while (t_rdy < 0 && k < 1000) begin
            @(negedge clk);
            k++;
            if (k == 1) begin
                chk(!ready && !odt_en, "R2 start", {ready, odt_en}, 0);
                chk(cmd == (bank ? 2'b01 : 2'b00), "R2 precharge", cmd, bank ? 1 : 0);
            end
            if (!ready) chk(!odt_en, "R3 odt held off", odt_en, 0);
            if (cmd == 2'b01) n_pre++;
            if (cmd == 2'b10) begin n_dll++; if (t_dll < 0) t_dll = k; end
            if (!cke && t_ckef < 0) t_ckef = k;
            if (cke && t_ckef >= 0 && t_ckeu < 0) t_ckeu = k;
            if (clk_sw_ok) n_sw++;
            if (clk_sw_ok && t_sw < 0) t_sw = k;
            if (ready && t_rdy < 0) t_rdy = k;
            // drive next inputs: noise on everything the block must ignore
            if (t_sw < 0) clk_stable = 1'($urandom);
            else          clk_stable = (k >= t_sw + dly);
            chg_req   = ready ? 1'b0 : 1'($urandom);
            odt_req   = 1'($urandom);
            bank_open = 1'($urandom);
            cfg_trp   = CFG_W'($urandom); cfg_taofd = CFG_W'($urandom); cfg_txp = CFG_W'($urandom);
        end
        m = exp_m(trp, taofd, bank);
        chk(t_ckef == m + 3, "R4 cke fall", t_ckef, m + 3);
        chk(t_sw == t_ckef + 2, "R5 switch rise", t_sw, t_ckef + 2);
        chk(n_sw == dly + 1, "R5 switch width", n_sw, dly + 1);
        chk(t_ckeu == t_sw + dly + 1, "R6 cke rise", t_ckeu, t_sw + dly + 1);
        chk(t_dll == t_ckeu + txp + 1, "R7 dll reset", t_dll, t_ckeu + txp + 1);
        chk(t_rdy == t_dll + RELOCK + 1, "R8 ready", t_rdy, t_dll + RELOCK + 1);
        chk(n_pre == int'(bank) && n_dll == 1, "R9 commands", n_pre * 10 + n_dll, int'(bank) * 10 + 1);
        // R10: intervals above follow captured config despite per-cycle config noise
        chk(t_dll - t_ckeu == txp + 1 && t_ckef == m + 3, "R10 captured cfg", t_dll - t_ckeu, txp + 1);
        clk_stable = 1'b0;
        idle_check(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        odt_req = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ready && cke && cmd == 2'b00 && !clk_sw_ok, "R1 reset", {ready, cke, clk_sw_ok}, 3'b110);
        chk(odt_en == 1'b1, "R1 reset odt", odt_en, 1);
        idle_check(4);
        // directed corners
        run_seq(0, 0, 0, 1'b1, 0);
        run_seq(15, 3, 15, 1'b1, 5);
        run_seq(3, 15, 0, 1'b0, 2);
        run_seq(15, 2, 4, 1'b0, 1);
        run_seq(15, 15, 15, 1'b1, 0);
        // constrained random
        void'($urandom(32'd1234));
        for (int s = 0; s < 40; s++)
            run_seq($urandom % 16, $urandom % 16, $urandom % 16, 1'($urandom), $urandom % 6);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule